// File: doc/BRIEF.md
# Banked Legacy Interrupt Controller

This block gathers device interrupt lines in banks of 32 and presents them to a processor as one registered request. Each bank holds four 32-bit registers on a small synchronous register bus: a latched-event register, an enable register, a write-one-to-clear acknowledge register and a raw line-state register. A fixed per-controller mask splits each bank's sources into two kinds. Level-type sources are taken straight from the input lines. Edge-type sources are caught on a rising edge and held until software acknowledges them.

A primary controller with `BANKS` banks drives the processor request. An optional secondary controller has the same layout and its own level mask. The secondary's combined pending state feeds one source line of the primary as a cascade, and it is also brought out as a port. Next to the request, the block gives a registered index of the highest-numbered pending primary source, so software can go straight to the source it should service.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every enable and event register reads 0, `irq` is 0 and `irq_src` is 0.
- R2: An edge-type source latches its event bit on a rising edge of its line while its enable bit is 1. The bit stays set after the line falls, until it is acknowledged.
- R3: A source is level-type when its bit is set in the controller's level mask (primary 0x3ff00000, secondary 0x1ff00000). A level-type source never sets its event bit, and its pending state follows the line with no acknowledge.
- R4: Writing the acknowledge register clears each event bit written as 1. Bits written as 0 leave their events untouched. The acknowledge register reads as 0.
- R5: A rising edge on an edge-type line whose enable bit is 0 latches nothing.
- R6: Setting an enable bit while its line is already high latches no event and raises no request.
- R7: A bank's pending set is (event OR (line AND level mask)) AND enable. `irq` is the registered OR of all primary pending bits, and it changes on the clock edge after the change that caused it. `irq_src` is registered with it and holds bank*32+bit of the highest-numbered pending primary source, or 0 when nothing is pending.
- R8: Address map: bits [3:2] select the register (0 event, 1 enable, 2 acknowledge, 3 line state). Bank 0 sits at 0x20 and bank 1 at 0x10 of a controller. Address bit 6 selects the secondary controller. The line-state register returns the current input lines of that bank, and primary bit 21 of bank 0 shows the cascade.
- R9: The OR of the secondary's pending bits appears on `cascade_req` and replaces primary bank-0 line 21. The external `pri_lines[21]` has no effect.
- R10: When an acknowledge of an event bit and a new latching rising edge of that source fall on the same clock edge, the event bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_lines | input | 32*BANKS | Primary controller interrupt lines |
| sec_lines | input | 32*BANKS | Secondary controller interrupt lines |
| bus_addr | input | $clog2(BANKS+1)+5 | Register byte address |
| bus_wr | input | 1 | Write strobe, taken on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational, zero wait states |
| irq | output | 1 | Registered interrupt request to the processor |
| irq_src | output | $clog2(32*BANKS) | Registered index of the highest-numbered pending primary source |
| cascade_req | output | 1 | Secondary controller's combined pending state |

## Verification
Register reads are combinational, so the bench samples `bus_rdata` in the same low clock phase in which it presents the address. A register write or a level-line change reaches `irq` and `irq_src` on the next rising edge. An edge-type rising line first latches its event on one edge and reaches `irq` on the edge after that. A secondary event shows on `cascade_req` right after its latch edge and on the primary request one edge later. The driver applies all stimulus at falling edges and steps exactly that many falling edges before it queues each expectation, and the monitor compares each popped item against the ports at that moment.

// File: rtl/bic_pkg.sv
// Package: shared constants and types for the banked interrupt controller.
// Assumes every bank carries exactly 32 sources and 32-bit registers.
package bic_pkg;
    localparam int unsigned SRC_PER_BANK = 32;
    localparam int unsigned DATA_W       = 32;

    // Register select, taken from address bits [3:2] inside a bank block.
    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_LINES  = 2'd3
    } reg_sel_e;

    // Per-bank write command decoded from the register bus.
    typedef struct packed {
        logic              set_enable;
        logic              do_ack;
        logic [DATA_W-1:0] data;
    } bank_wr_t;
endpackage

// File: rtl/bic_bank.sv
// Module: one bank of 32 sources. Holds the enable and event registers,
// detects rising edges against a registered copy of the lines, and forms
// the pending set. Assumes the lines are already synchronous to clk.
module bic_bank
    import bic_pkg::*;
#(
    parameter logic [31:0] LVL_MASK = 32'h3ff0_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] lines,
    input  bank_wr_t    wr,
    output logic [31:0] event_o,
    output logic [31:0] enable_o,
    output logic [31:0] pending_o
);
    logic [31:0] line_q;
    logic [31:0] event_q;
    logic [31:0] en_q;
    logic [31:0] rise;
    logic [31:0] latch_set;
    logic [31:0] ack_clr;

    // Rising edges and the subset that may latch (edge-type and enabled).
    always_comb begin
        rise      = lines & ~line_q;
        latch_set = rise & en_q & ~LVL_MASK;
        ack_clr   = wr.do_ack ? wr.data : 32'h0;
    end

    // Keep the previous line state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= lines;
    end

    // Enable register, written whole by software.
    always_ff @(posedge clk) begin
        if (!rst_n)             en_q <= '0;
        else if (wr.set_enable) en_q <= wr.data;
    end

    // Event latch: acknowledge clears, a new edge wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) event_q <= '0;
        else        event_q <= (event_q & ~ack_clr) | latch_set;
    end

    // Pending set combines latched edges with raw level-type lines.
    always_comb begin
        pending_o = (event_q | (lines & LVL_MASK)) & en_q;
    end

    assign event_o  = event_q;
    assign enable_o = en_q;

    // R3: level-type sources never appear in the event latch.
    a_r3_level_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (event_q & LVL_MASK) == 32'h0);

    // R5: no event bit becomes set while its enable was 0.
    a_r5_no_latch_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((event_q & ~$past(event_q) & ~$past(en_q)) == 32'h0));

    // R2: without an acknowledge, latched events are kept.
    a_r2_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr.do_ack |=> ((event_q & $past(event_q)) == $past(event_q)));

    // R4: acknowledged bits without a concurrent rising edge are cleared.
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr.do_ack |=> ((event_q & $past(wr.data) & ~$past(rise)) == 32'h0));
endmodule

// File: rtl/bic_prio.sv
// Module: finds the highest-numbered set bit of a vector.
// Assumes N is at least 2; returns index 0 when no bit is set.
module bic_prio #(
    parameter int unsigned N     = 64,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan upward so the last set bit found is the highest.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/bic_ctrl.sv
// Module: one controller of BANKS banks with its register decode.
// Bank b sits at block (BANKS-b)*0x10, so bank 0 is highest in the window.
// Assumes single-cycle writes and combinational reads.
module bic_ctrl
    import bic_pkg::*;
#(
    parameter int unsigned BANKS    = 2,
    parameter logic [31:0] LVL_MASK = 32'h3ff0_0000,
    localparam int unsigned N       = SRC_PER_BANK * BANKS,
    localparam int unsigned BLK_W   = $clog2(BANKS + 1),
    localparam int unsigned SPAN_W  = BLK_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      lines,
    input  logic              wr_en,
    input  logic [SPAN_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [N-1:0]      pending
);
    logic [BLK_W-1:0] blk;
    reg_sel_e         rsel;
    logic [31:0]      ev_arr [BANKS];
    logic [31:0]      en_arr [BANKS];

    assign blk  = addr[SPAN_W-1:4];
    assign rsel = reg_sel_e'(addr[3:2]);

    for (genvar b = 0; b < int'(BANKS); b++) begin : g_bank
        localparam logic [BLK_W-1:0] MY_BLK = BLK_W'(BANKS - b);
        bank_wr_t cmd;
        logic     hit;

        // Decode a write aimed at this bank.
        always_comb begin
            hit            = wr_en && (blk == MY_BLK);
            cmd.set_enable = hit && (rsel == REG_ENABLE);
            cmd.do_ack     = hit && (rsel == REG_ACK);
            cmd.data       = wdata;
        end

        bic_bank #(.LVL_MASK(LVL_MASK)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .lines     (lines[b*32 +: 32]),
            .wr        (cmd),
            .event_o   (ev_arr[b]),
            .enable_o  (en_arr[b]),
            .pending_o (pending[b*32 +: 32])
        );
    end

    // Read mux: select bank by block, then register by rsel.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < int'(BANKS); b++) begin
            if (blk == BLK_W'(int'(BANKS) - b)) begin
                case (rsel)
                    REG_EVENT:  rdata = ev_arr[b];
                    REG_ENABLE: rdata = en_arr[b];
                    REG_LINES:  rdata = lines[b*32 +: 32];
                    default:    rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/banked_irq_ctrl.sv
// Module: top of the banked interrupt controller. A primary controller
// drives the registered request; an optional secondary controller cascades
// into primary source CASCADE_SRC, which must be a level-type bit there.
// Address bit ADDR_W-1 selects the secondary controller.
module banked_irq_ctrl
    import bic_pkg::*;
#(
    parameter int unsigned BANKS        = 2,
    parameter logic [31:0] PRI_LVL_MASK = 32'h3ff0_0000,
    parameter logic [31:0] SEC_LVL_MASK = 32'h1ff0_0000,
    parameter bit          HAS_SEC      = 1'b1,
    parameter int unsigned CASCADE_SRC  = 21
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [32*BANKS-1:0]               pri_lines,
    input  logic [32*BANKS-1:0]               sec_lines,
    input  logic [$clog2(BANKS+1)+4:0]        bus_addr,
    input  logic                              bus_wr,
    input  logic [31:0]                       bus_wdata,
    output logic [31:0]                       bus_rdata,
    output logic                              irq,
    output logic [$clog2(32*BANKS)-1:0]       irq_src,
    output logic                              cascade_req
);
    localparam int unsigned N      = SRC_PER_BANK * BANKS;
    localparam int unsigned BLK_W  = $clog2(BANKS + 1);
    localparam int unsigned SPAN_W = BLK_W + 4;
    localparam int unsigned ADDR_W = SPAN_W + 1;
    localparam int unsigned IDX_W  = $clog2(N);

    logic              sec_sel;
    logic [N-1:0]      pri_in;
    logic [N-1:0]      pri_pending;
    logic [31:0]       pri_rdata;
    logic [31:0]       sec_rdata;
    logic              cascade;
    logic              any_pending;
    logic [IDX_W-1:0]  top_idx;
    logic              irq_q;
    logic [IDX_W-1:0]  src_q;

    assign sec_sel = bus_addr[ADDR_W-1];

    if (HAS_SEC) begin : g_sec
        logic [N-1:0] sec_pending;

        bic_ctrl #(.BANKS(BANKS), .LVL_MASK(SEC_LVL_MASK)) u_sec (
            .clk     (clk),
            .rst_n   (rst_n),
            .lines   (sec_lines),
            .wr_en   (bus_wr && sec_sel),
            .addr    (bus_addr[SPAN_W-1:0]),
            .wdata   (bus_wdata),
            .rdata   (sec_rdata),
            .pending (sec_pending)
        );

        // Combined secondary request replaces one primary line.
        always_comb begin
            cascade             = |sec_pending;
            pri_in              = pri_lines;
            pri_in[CASCADE_SRC] = cascade;
        end
    end else begin : g_nosec
        // Without a secondary the primary sees its lines unchanged.
        always_comb begin
            cascade   = 1'b0;
            pri_in    = pri_lines;
            sec_rdata = '0;
        end
    end

    bic_ctrl #(.BANKS(BANKS), .LVL_MASK(PRI_LVL_MASK)) u_pri (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines   (pri_in),
        .wr_en   (bus_wr && !sec_sel),
        .addr    (bus_addr[SPAN_W-1:0]),
        .wdata   (bus_wdata),
        .rdata   (pri_rdata),
        .pending (pri_pending)
    );

    bic_prio #(.N(N)) u_prio (
        .vec (pri_pending),
        .any (any_pending),
        .idx (top_idx)
    );

    // Register the request and the index of the source to service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            src_q <= '0;
        end else begin
            irq_q <= any_pending;
            src_q <= top_idx;
        end
    end

    assign bus_rdata   = sec_sel ? sec_rdata : pri_rdata;
    assign irq         = irq_q;
    assign irq_src     = src_q;
    assign cascade_req = cascade;

    // R7: with no request the reported source index is 0.
    a_r7_src_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_q |-> (src_q == '0));

    // R7: the request follows the primary pending set by one clock edge.
    a_r7_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (|pri_pending) |=> irq_q);
endmodule

// File: tb/sim_banked_irq_ctrl.sv
`timescale 1ns/10ps
module sim_banked_irq_ctrl;
    localparam int BANKS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pri_lines = '0;
    logic [63:0] sec_lines = '0;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [5:0]  irq_src;
    logic        cascade_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;     // 0 read data, 1 irq and source, 2 cascade
        logic [31:0] exp;
        int          exp_src;
        string       req;
    } item_t;
    item_t sb[$];

    banked_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pri_lines(pri_lines), .sec_lines(sec_lines),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .irq_src(irq_src),
        .cascade_req(cascade_req)
    );

    always #2 clk = ~clk;

    function automatic logic [6:0] pa(int bank, int r);
        return {1'b0, 2'(2 - bank), 2'(r), 2'b00};
    endfunction
    function automatic logic [6:0] sa(int bank, int r);
        return {1'b1, 2'(2 - bank), 2'(r), 2'b00};
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(int kind, logic [31:0] exp, int src, string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.exp_src = src; it.req = req;
        sb.push_back(it);
        #0.05;
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, logic [31:0] exp, string req);
        bus_addr = a;
        #0.05;
        push(0, exp, 0, req);
    endtask

    task automatic chk_irq(logic e, int src, string req);
        push(1, {31'h0, e}, src, req);
    endtask

    task automatic chk_casc(logic e, string req);
        push(2, {31'h0, e}, 0, req);
    endtask

    // Monitor: pops expectations and compares them with the ports.
    initial begin
        item_t it;
        forever begin
            wait (sb.size() != 0);
            it = sb.pop_front();
            checks++;
            case (it.kind)
                0: if (bus_rdata !== it.exp) begin
                       errors++;
                       $display("FAIL %s: rdata addr %h got %h exp %h",
                                it.req, bus_addr, bus_rdata, it.exp);
                   end
                1: if (irq !== it.exp[0] || int'(irq_src) != it.exp_src) begin
                       errors++;
                       $display("FAIL %s: irq/src got %b/%0d exp %b/%0d",
                                it.req, irq, irq_src, it.exp[0], it.exp_src);
                   end
                default: if (cascade_req !== it.exp[0]) begin
                       errors++;
                       $display("FAIL %s: cascade_req got %b exp %b",
                                it.req, cascade_req, it.exp[0]);
                   end
            endcase
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk_irq(0, 0, "R1");
        rd(pa(0, 1), 32'h0, "R1");
        rd(pa(1, 0), 32'h0, "R1");
        rd(sa(0, 1), 32'h0, "R1");

        // R2 edge latch and stickiness
        wr(pa(0, 1), 32'h8);
        pri_lines[3] = 1'b1;
        step(2);
        chk_irq(1, 3, "R2");
        rd(pa(0, 0), 32'h8, "R2");
        pri_lines[3] = 1'b0;
        step(2);
        rd(pa(0, 0), 32'h8, "R2");
        chk_irq(1, 3, "R2");

        // R4 acknowledge semantics
        wr(pa(0, 2), 32'h10);
        rd(pa(0, 0), 32'h8, "R4");
        rd(pa(0, 2), 32'h0, "R4");
        wr(pa(0, 2), 32'h8);
        rd(pa(0, 0), 32'h0, "R4");
        step(1);
        chk_irq(0, 0, "R4");

        // R10 acknowledge and new edge on the same clock edge
        pri_lines[3] = 1'b1; step(1);
        pri_lines[3] = 1'b0; step(1);
        pri_lines[3] = 1'b1;
        wr(pa(0, 2), 32'h8);
        rd(pa(0, 0), 32'h8, "R10");
        pri_lines[3] = 1'b0;
        wr(pa(0, 2), 32'h8);
        rd(pa(0, 0), 32'h0, "R10");

        // R5 edge on a disabled line; R6 enabling a line already high
        pri_lines[6] = 1'b1;
        step(2);
        rd(pa(0, 0), 32'h0, "R5");
        wr(pa(0, 1), 32'h48);
        step(2);
        rd(pa(0, 0), 32'h0, "R6");
        chk_irq(0, 0, "R6");
        pri_lines[6] = 1'b0;

        // R3 level-type source on the primary
        wr(pa(0, 1), 32'h0200_0000);
        pri_lines[25] = 1'b1;
        step(1);
        chk_irq(1, 25, "R3");
        rd(pa(0, 0), 32'h0, "R3");
        rd(pa(0, 3), 32'h0200_0000, "R8");
        pri_lines[25] = 1'b0;
        step(1);
        chk_irq(0, 0, "R3");

        // R7 highest-numbered pending source across banks
        wr(pa(0, 1), 32'h8);
        wr(pa(1, 1), 32'h100);
        pri_lines[3] = 1'b1; pri_lines[40] = 1'b1;
        step(1);
        pri_lines[3] = 1'b0; pri_lines[40] = 1'b0;
        step(1);
        chk_irq(1, 40, "R7");
        wr(pa(1, 2), 32'h100);
        step(1);
        chk_irq(1, 3, "R7");
        wr(pa(0, 2), 32'h8);
        step(1);
        chk_irq(0, 0, "R7");

        // R8 bank placement in the window
        wr(pa(1, 1), 32'ha5a5_0000);
        rd(7'h14, 32'ha5a5_0000, "R8");
        rd(7'h24, 32'h8, "R8");
        wr(pa(1, 1), 32'h0);

        // R9 cascade from the secondary
        wr(pa(0, 1), 32'h0020_0000);
        wr(sa(0, 1), 32'h80);
        pri_lines[21] = 1'b1;
        step(2);
        chk_irq(0, 0, "R9");
        pri_lines[21] = 1'b0;
        sec_lines[7] = 1'b1;
        step(1);
        chk_casc(1, "R9");
        step(1);
        chk_irq(1, 21, "R9");
        sec_lines[7] = 1'b0;
        wr(sa(0, 2), 32'h80);
        chk_casc(0, "R9");
        step(1);
        chk_irq(0, 0, "R9");

        // R3 secondary mask: bit 29 edge-type, bit 28 level-type
        wr(sa(0, 1), 32'h3000_0000);
        sec_lines[29] = 1'b1; sec_lines[28] = 1'b1;
        step(2);
        rd(sa(0, 0), 32'h2000_0000, "R3");
        chk_irq(1, 21, "R3");
        sec_lines[28] = 1'b0; sec_lines[29] = 1'b0;
        wr(sa(0, 2), 32'h2000_0000);
        chk_casc(0, "R3");

        step(2);
        wait (sb.size() == 0);
        #0.1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule